// File: doc/BRIEF.md
# Dual-Plane Erase, Suspend and Lockout Manager

This block runs the state of a flash array that is split into two independently busy planes across 40 sectors. A command interpreter hands it single-cycle requests: word program, sector erase, chip erase, erase suspend, erase resume, and set sector lock. The block decides whether each request is accepted. It times accepted operations with a tick prescaler and reports busy, suspended and done for each plane. It also drives a per-sector mask that marks the sectors an erase is allowed to clear.

Plane A holds sectors 0 to 15, which are the small boot sectors plus six large ones. Plane B holds sectors 16 to 39. One plane can program or erase while the other is idle or busy with its own work. A running erase can be frozen so that other sectors of the same plane can be programmed, and it can later be restarted from where it stopped.

A lock bit per sector turns program and erase requests into rejections or early aborts. A high-voltage override input lifts the locks while it is asserted. The `TOP_BOOT` parameter moves plane A to the high sector numbers.

Top module: `dual_plane_erase_mgr`

## Requirements
- R1: While rst_n is low, busy, susp, done, rej and emask are all zero, any operation in progress is dropped and every lock bit is cleared.
- R2: A program request (req_op 1) to an unlocked sector whose plane is idle holds that plane's busy bit high for PROG_TICKS ticks. done for that plane then pulses for one cycle, in the cycle busy falls. Sectors 0..15 belong to plane A (index 0) and sectors 16..39 to plane B (index 1).
- R3: A sector erase request (req_op 2) to an unlocked sector in an idle plane sets that sector's emask bit and holds busy for ERASE_TICKS ticks. At the end it pulses done and clears the bit.
- R4: Any request aimed at a plane that is busy has no effect on that plane's timing and produces no rejection.
- R5: Work on one plane is accepted and completes while the other plane is busy.
- R6: A lock request (req_op 6) marks a sector locked. A program to a locked sector without override is rejected: rej and done pulse together in the following cycle, and busy stays low. A sector erase to a locked sector without override sets no emask bit and is busy for only ABORT_TICKS ticks before done.
- R7: When hv_ovr is high at the request cycle, locked sectors are programmed and erased as if unlocked.
- R8: A chip erase (req_op 3) is accepted only when both planes are idle. It sets emask to all unlocked sectors, or to all sectors under override, and keeps both planes busy for ERASE_TICKS ticks.
- R9: A suspend request (req_op 4) carries no address. Each plane that is erasing stays busy for SUSP_TICKS more ticks with its erase progress frozen, then shows susp high and busy low.
- R10: While a plane is suspended, a program to a sector outside the frozen erase is run: busy for PROG_TICKS, susp held, done pulsed. A program to a frozen sector is ignored, and no sector or chip erase is accepted on either plane.
- R11: A resume request (req_op 5) restarts only the plane chosen by req_pbits, the two top address bits: 00 selects plane A and any other value selects plane B. That plane is busy for exactly the erase ticks left at suspension and then pulses done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; aborts all work |
| req_valid | input | 1 | One-cycle request strobe |
| req_op | input | 3 | Request code: 1 program, 2 sector erase, 3 chip erase, 4 suspend, 5 resume, 6 lock |
| req_sect | input | 6 | Target sector number |
| req_pbits | input | 2 | Top two address bits, used by resume to pick the plane |
| hv_ovr | input | 1 | High-voltage override; lifts sector locks while high |
| busy | output | 2 | Per-plane busy |
| susp | output | 2 | Per-plane erase suspended |
| done | output | 2 | Per-plane one-cycle completion pulse |
| rej | output | 1 | One-cycle pulse for a program refused by a lock |
| emask | output | 40 | Sectors the running or frozen erase covers |

## Verification
Some properties are checked on every cycle. Busy may only fall together with done or with entry into suspension, and suspension is entered only from a busy plane. No erase bit may appear while any plane is suspended, a locked sector may never join the erase mask without the override, a rejection always comes with a done pulse, and a nonzero mask always belongs to a busy or suspended plane. Other behaviour needs the bench's scenarios: exact tick durations, the frozen remaining count after a suspend, and resume choosing a plane from the address bits. The same goes for a program ignored on a busy plane leaving timing unchanged, chip-erase masks with and without override, and locks cleared by reset.

// File: rtl/dual_plane_erase_mgr.sv
`timescale 1ns/1ps
module dual_plane_erase_mgr #(
  parameter int NUM_SECT     = 40,
  parameter int PLANE_A_SECT = 16,
  parameter bit TOP_BOOT     = 1'b0,
  parameter int TICK_DIV     = 50,
  parameter int PROG_TICKS   = 10,
  parameter int ERASE_TICKS  = 2000,
  parameter int ABORT_TICKS  = 2,
  parameter int SUSP_TICKS   = 15,
  localparam int SW = $clog2(NUM_SECT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [2:0]          req_op,
  input  logic [SW-1:0]       req_sect,
  input  logic [1:0]          req_pbits,
  input  logic                hv_ovr,
  output logic [1:0]          busy,
  output logic [1:0]          susp,
  output logic [1:0]          done,
  output logic                rej,
  output logic [NUM_SECT-1:0] emask
);
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int M1 = (PROG_TICKS > ERASE_TICKS) ? PROG_TICKS : ERASE_TICKS;
  localparam int M2 = (ABORT_TICKS > SUSP_TICKS) ? ABORT_TICKS : SUSP_TICKS;
  localparam int MAXT = (M1 > M2) ? M1 : M2;
  localparam int CW = $clog2(MAXT + 1);

  localparam logic [2:0] OP_PROG = 3'd1, OP_SERASE = 3'd2, OP_CERASE = 3'd3,
                         OP_SUSP = 3'd4, OP_RESUME = 3'd5, OP_LOCK   = 3'd6;

  typedef enum logic [2:0] {
    S_IDLE, S_PROG, S_ERASE, S_ABORT, S_SPEND, S_SUSP, S_SPROG
  } st_t;

  function automatic logic plane_of(input int s);
    return TOP_BOOT ? (s < NUM_SECT - PLANE_A_SECT) : (s >= PLANE_A_SECT);
  endfunction

  st_t                 st   [2];
  logic [CW-1:0]       ecnt [2];
  logic [CW-1:0]       ocnt [2];
  logic [DW-1:0]       pre;
  logic [NUM_SECT-1:0] lockq;
  logic [NUM_SECT-1:0] pm_b;
  logic [NUM_SECT-1:0] clr;
  logic [1:0]          fin_e;

  logic          tick;
  logic          sect_ok;
  logic [SW-1:0] sidx;
  logic          rp;
  logic          rbp;
  logic          locked;
  logic          in_emask;
  logic          susp_req;

  assign tick     = (pre == DW'(TICK_DIV - 1));
  assign sect_ok  = (int'(req_sect) < NUM_SECT);
  assign sidx     = sect_ok ? req_sect : '0;
  assign rp       = plane_of(int'(sidx));
  assign rbp      = TOP_BOOT ? (req_pbits != 2'b11) : (req_pbits != 2'b00);
  assign locked   = lockq[sidx] & ~hv_ovr;
  assign in_emask = emask[sidx];
  assign susp_req = req_valid && (req_op == OP_SUSP);

  for (genvar i = 0; i < NUM_SECT; i++) begin : g_pm
    assign pm_b[i] = plane_of(i);
  end

  for (genvar p = 0; p < 2; p++) begin : g_pl
    assign busy[p]  = (st[p] == S_PROG) || (st[p] == S_ERASE) || (st[p] == S_ABORT) ||
                      (st[p] == S_SPEND) || (st[p] == S_SPROG);
    assign susp[p]  = (st[p] == S_SUSP) || (st[p] == S_SPROG);
    assign fin_e[p] = (st[p] == S_ERASE) && tick && (ecnt[p] == CW'(1)) && !susp_req;
  end

  assign clr = (fin_e[0] ? ~pm_b : '0) | (fin_e[1] ? pm_b : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      st[0] <= S_IDLE;
      st[1] <= S_IDLE;
      ecnt[0] <= '0;
      ecnt[1] <= '0;
      ocnt[0] <= '0;
      ocnt[1] <= '0;
      emask <= '0;
      lockq <= '0;
      done  <= '0;
      rej   <= 1'b0;
    end else begin
      pre   <= tick ? '0 : pre + 1'b1;
      done  <= '0;
      rej   <= 1'b0;
      emask <= emask & ~clr;

      for (int p = 0; p < 2; p++) begin
        case (st[p])
          S_PROG, S_ABORT, S_SPROG: if (tick) begin
            if (ocnt[p] == CW'(1)) begin
              st[p]   <= (st[p] == S_SPROG) ? S_SUSP : S_IDLE;
              done[p] <= 1'b1;
            end else ocnt[p] <= ocnt[p] - 1'b1;
          end
          S_SPEND: if (tick) begin
            if (ocnt[p] == CW'(1)) st[p] <= S_SUSP;
            else ocnt[p] <= ocnt[p] - 1'b1;
          end
          S_ERASE: if (tick && !susp_req) begin
            if (fin_e[p]) begin
              st[p]   <= S_IDLE;
              done[p] <= 1'b1;
            end else ecnt[p] <= ecnt[p] - 1'b1;
          end
          default: ;
        endcase
      end

      if (req_valid) begin
        case (req_op)
          OP_PROG: if (sect_ok) begin
            if (st[rp] == S_IDLE || (st[rp] == S_SUSP && !in_emask)) begin
              if (locked) begin
                done[rp] <= 1'b1;
                rej      <= 1'b1;
              end else begin
                st[rp]   <= (st[rp] == S_IDLE) ? S_PROG : S_SPROG;
                ocnt[rp] <= CW'(PROG_TICKS);
              end
            end
          end
          OP_SERASE: if (sect_ok && st[rp] == S_IDLE && !susp[!rp] && st[!rp] != S_SPEND) begin
            if (locked) begin
              st[rp]   <= S_ABORT;
              ocnt[rp] <= CW'(ABORT_TICKS);
            end else begin
              st[rp]      <= S_ERASE;
              ecnt[rp]    <= CW'(ERASE_TICKS);
              emask[sidx] <= 1'b1;
            end
          end
          OP_CERASE: if (st[0] == S_IDLE && st[1] == S_IDLE) begin
            st[0]   <= S_ERASE;
            st[1]   <= S_ERASE;
            ecnt[0] <= CW'(ERASE_TICKS);
            ecnt[1] <= CW'(ERASE_TICKS);
            emask   <= hv_ovr ? '1 : ~lockq;
          end
          OP_SUSP: for (int p = 0; p < 2; p++) begin
            if (st[p] == S_ERASE) begin
              st[p]   <= S_SPEND;
              ocnt[p] <= CW'(SUSP_TICKS);
            end
          end
          OP_RESUME: if (st[rbp] == S_SUSP) st[rbp] <= S_ERASE;
          OP_LOCK: if (sect_ok) lockq[sidx] <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dual_plane_erase_mgr_chk.sv
`timescale 1ns/1ps
module dual_plane_erase_mgr_chk #(
  parameter int N = 40
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   busy,
  input logic [1:0]   susp,
  input logic [1:0]   done,
  input logic         rej,
  input logic         hv_ovr,
  input logic [N-1:0] emask,
  input logic [N-1:0] lockq
);
  for (genvar p = 0; p < 2; p++) begin : g_p
    // R2
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[p]) |-> (done[p] || susp[p]));
    // R9
    susp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(susp[p]) |-> $past(busy[p]));
  end

  // R10
  no_new_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (susp != 2'b00) |=> ((emask & ~$past(emask)) == '0));

  // R6
  lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((emask & ~$past(emask)) & $past(lockq) & ~{N{$past(hv_ovr)}}) == '0);

  // R6
  rej_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rej |-> (done != 2'b00));

  // R3
  mask_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emask != '0) |-> ((busy | susp) != 2'b00));
endmodule

bind dual_plane_erase_mgr dual_plane_erase_mgr_chk #(.N(NUM_SECT)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .susp(susp), .done(done),
  .rej(rej), .hv_ovr(hv_ovr), .emask(emask), .lockq(lockq)
);

// File: tb/dual_plane_erase_mgr_test.sv
`timescale 1ns/1ps
module dual_plane_erase_mgr_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_op;
  logic [5:0]  req_sect;
  logic [1:0]  req_pbits;
  logic        hv_ovr;
  logic [1:0]  busy, susp, done;
  logic        rej;
  logic [39:0] emask;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  dual_plane_erase_mgr #(
    .TICK_DIV(1), .PROG_TICKS(3), .ERASE_TICKS(12), .ABORT_TICKS(2), .SUSP_TICKS(2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_sect(req_sect), .req_pbits(req_pbits), .hv_ovr(hv_ovr),
    .busy(busy), .susp(susp), .done(done), .rej(rej), .emask(emask)
  );

  // {op, sector, override, plane, busy cycles, reject, mask bit}
  localparam logic [17:0] VEC [10] = '{
    {3'd1, 6'd5,  1'b0, 1'b0, 5'd3,  1'b0, 1'b0},
    {3'd1, 6'd3,  1'b0, 1'b0, 5'd0,  1'b1, 1'b0},
    {3'd1, 6'd3,  1'b1, 1'b0, 5'd3,  1'b0, 1'b0},
    {3'd2, 6'd20, 1'b0, 1'b1, 5'd2,  1'b0, 1'b0},
    {3'd2, 6'd20, 1'b1, 1'b1, 5'd12, 1'b0, 1'b1},
    {3'd2, 6'd30, 1'b0, 1'b1, 5'd12, 1'b0, 1'b1},
    {3'd1, 6'd39, 1'b0, 1'b1, 5'd3,  1'b0, 1'b0},
    {3'd2, 6'd0,  1'b0, 1'b0, 5'd12, 1'b0, 1'b1},
    {3'd2, 6'd15, 1'b0, 1'b0, 5'd12, 1'b0, 1'b1},
    {3'd1, 6'd16, 1'b0, 1'b1, 5'd3,  1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [5:0] s,
                       input logic [1:0] pb, input logic ov);
    req_valid = 1'b1; req_op = op; req_sect = s; req_pbits = pb; hv_ovr = ov;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; hv_ovr = 1'b0;
  endtask

  task automatic wait_busy(input int p, output int n);
    n = 0;
    while (busy[p] && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [2:0] op; logic [5:0] s; logic ov, pl, er, em; logic [4:0] eb;
    logic [39:0] expm;
    int n;
    bit saw;
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_sect = '0;
    req_pbits = '0; hv_ovr = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && susp == 0 && done == 0 && rej == 0 && emask == 0,
        "R1", "reset outputs", {busy, susp, done, rej}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    issue(3'd6, 6'd3, 2'b00, 1'b0);
    issue(3'd6, 6'd20, 2'b00, 1'b0);

    for (int i = 0; i < 10; i++) begin
      {op, s, ov, pl, eb, er, em} = VEC[i];
      issue(op, s, 2'b00, ov);
      chk(emask[s] == em, "R3/R6/R7", $sformatf("row %0d mask bit", i), emask[s], em);
      chk(rej == er, "R6", $sformatf("row %0d reject", i), rej, er);
      wait_busy(int'(pl), n);
      chk(n == int'(eb), "R2/R3/R6/R7", $sformatf("row %0d busy cycles", i), n, eb);
      chk(done[pl] == 1'b1, "R2", $sformatf("row %0d done", i), done, 1);
      @(negedge clk);
      chk(emask == 0, "R3", $sformatf("row %0d mask cleared", i), emask, 0);
    end

    // R5 and R4: concurrent planes, ignored request to busy plane
    issue(3'd2, 6'd30, 2'b00, 1'b0);
    issue(3'd1, 6'd5, 2'b00, 1'b0);
    chk(busy == 2'b11, "R5", "both planes busy", busy, 3);
    issue(3'd1, 6'd35, 2'b00, 1'b0);
    chk(rej == 1'b0, "R4", "no reject on busy plane", rej, 0);
    n = 0; saw = 0;
    while (busy[1] && n < 200) begin
      if (done[0]) saw = 1;
      n++;
      @(negedge clk);
    end
    chk(saw, "R5", "plane A done during plane B erase", saw, 1);
    chk(n == 10, "R4", "plane B erase length unchanged", n, 10);
    @(negedge clk);

    // R8: chip erase skipping locked sectors
    expm = '1; expm[3] = 1'b0; expm[20] = 1'b0;
    issue(3'd3, 6'd0, 2'b00, 1'b0);
    chk(emask == expm, "R8", "chip mask skips locks", emask, expm);
    chk(busy == 2'b11, "R8", "chip busy both", busy, 3);
    wait_busy(0, n);
    chk(n == 12, "R8", "chip erase length", n, 12);
    chk(done == 2'b11 && emask == 0, "R8", "chip done", {done, emask}, 3);
    @(negedge clk);

    // R7/R8/R9/R11: override chip erase, suspend both, resume one
    issue(3'd3, 6'd0, 2'b00, 1'b1);
    chk(emask == '1, "R7", "override chip mask", emask, 40'hFF_FFFF_FFFF);
    repeat (2) @(negedge clk);
    issue(3'd4, 6'd0, 2'b00, 1'b0);
    chk(busy == 2'b11, "R9", "busy during suspend latency", busy, 3);
    @(negedge clk);
    chk(busy == 2'b11 && susp == 2'b00, "R9", "still latency", {busy, susp}, 12);
    @(negedge clk);
    chk(busy == 2'b00 && susp == 2'b11, "R9", "both suspended", {busy, susp}, 3);
    issue(3'd5, 6'd0, 2'b00, 1'b0);
    chk(busy == 2'b01 && susp == 2'b10, "R11", "resume plane A only", {busy, susp}, 6);
    wait_busy(0, n);
    chk(n == 10, "R11", "plane A remaining ticks", n, 10);
    chk(emask == {24'hFF_FFFF, 16'h0}, "R11", "plane B mask kept", emask, {24'hFF_FFFF, 16'h0});
    issue(3'd5, 6'd0, 2'b10, 1'b0);
    wait_busy(1, n);
    chk(n == 10 && emask == 0 && susp == 0, "R11", "plane B resumed", n, 10);
    @(negedge clk);

    // R9/R10/R11: sector erase suspend
    issue(3'd2, 6'd21, 2'b00, 1'b0);
    repeat (3) @(negedge clk);
    issue(3'd4, 6'd0, 2'b00, 1'b0);
    chk(busy[1] == 1'b1, "R9", "latency cycle 1", busy, 2);
    @(negedge clk);
    chk(busy[1] == 1'b1, "R9", "latency cycle 2", busy, 2);
    @(negedge clk);
    chk(busy == 0 && susp == 2'b10, "R9", "suspended", {busy, susp}, 2);
    issue(3'd2, 6'd22, 2'b00, 1'b0);
    chk(busy == 0 && emask[22] == 0, "R10", "second erase same plane refused", {busy, emask[22]}, 0);
    issue(3'd2, 6'd6, 2'b00, 1'b0);
    chk(busy == 0 && emask[6] == 0, "R10", "erase other plane refused", {busy, emask[6]}, 0);
    issue(3'd3, 6'd0, 2'b00, 1'b0);
    chk(busy == 0 && emask == (40'h1 << 21), "R10", "chip erase refused", emask, 40'h1 << 21);
    issue(3'd1, 6'd21, 2'b00, 1'b0);
    chk(busy == 0, "R10", "program of frozen sector ignored", busy, 0);
    issue(3'd1, 6'd22, 2'b00, 1'b0);
    chk(busy[1] == 1 && susp[1] == 1, "R10", "program during suspend", {busy, susp}, 10);
    wait_busy(1, n);
    chk(n == 3 && done[1] == 1 && susp[1] == 1, "R10", "suspend program done", n, 3);
    issue(3'd5, 6'd0, 2'b00, 1'b0);
    chk(busy == 0 && susp == 2'b10, "R11", "resume wrong plane ignored", {busy, susp}, 2);
    issue(3'd5, 6'd0, 2'b01, 1'b0);
    wait_busy(1, n);
    chk(n == 9, "R11", "remaining erase ticks", n, 9);
    chk(done[1] == 1 && emask == 0 && susp == 0, "R11", "erase completed", {done, susp}, 8);
    @(negedge clk);

    // R1: reset mid-erase clears work and locks
    issue(3'd2, 6'd25, 2'b00, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(busy == 0 && susp == 0 && emask == 0 && done == 0, "R1", "reset aborts", {busy, emask}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    issue(3'd1, 6'd3, 2'b00, 1'b0);
    chk(rej == 0 && busy[0] == 1, "R1", "locks cleared", {rej, busy}, 1);
    wait_busy(0, n);
    chk(n == 3, "R1", "program after reset", n, 3);

    finish_run();
  end
endmodule